// File: doc/BRIEF.md
# Two-Pipe Layer Compositor

This block builds every output pixel of a display from four overlay layers in two steps. Each layer is a rectangle with a signed origin, a width and a height. It also has an enable, a pipe assignment (0 or 1), a priority, and an 8-bit global alpha that has its own enable bit. Its ARGB pixel arrives on a per-layer input for the raster position being composed.

In the first step, each of the two pipes independently picks the enabled layer with the highest priority that covers the current raster position. In the second step, the pipe-1 pixel is alpha-blended over the pipe-0 pixel. Where pipe 0 has nothing, the background colour takes its place.

The block also reproduces a known corner-case defect of such compositors. A pipe-0 layer at priority 0 that is not fully opaque loses its pixel to the background colour.

The raster counters come from an external timing generator. The result appears two clock cycles after the inputs for a pixel are presented.

Top module: `layer_compositor`

## Requirements
- R1: `out_rgb` is registered and reflects the inputs sampled exactly two rising clock edges earlier. While `rst_n` is low, `out_rgb` is 0 (black).
- R2: A layer covers raster position (x, y) when `org_x <= x < org_x + width` and `org_y <= y < org_y + height`. Origins are 12-bit two's complement and may be negative. Raster coordinates are unsigned.
- R3: A layer whose enable bit is 0 never contributes to the output.
- R4: Within a pipe, the covering enabled layer with the numerically highest priority supplies the pixel. On equal priority, the lower layer index wins.
- R5: When no layer in pipe 0 covers the pixel, pipe 0 carries the background colour `bg_rgb`. The alpha of the pipe-0 winner is not used for blending; its RGB passes unchanged.
- R6: Pixel format is A[31:24], R[23:16], G[15:8], B[7:0]. The effective alpha of a layer is floor((A*G + 127)/255) when its global-alpha enable is 1, where G is the global alpha. When the enable is 0, the effective alpha is A, and the global alpha value has no effect.
- R7: Each output channel is floor((a*P1 + (255-a)*P0 + 127)/255). Here a is the effective alpha of the pipe-1 winner, or 0 if pipe 1 has no covering layer.
- R8: If the pipe-0 winner has priority 0 and effective alpha below 255, pipe 0 carries `bg_rgb` instead of that layer's colour.
- R9: Bit i of `lyr_pipe` assigns layer i to pipe 0 (bit 0) or pipe 1 (bit 1). Moving a layer between pipes changes whether its alpha takes part in blending.

Plain selection only needs opaque layers at integer coordinates, so most vectors exercise that case. In the defect case, R8 meets the blend of R7 in a single cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_x | input | 12 | Raster column of the pixel being composed |
| pix_y | input | 12 | Raster row of the pixel being composed |
| lyr_enable | input | 4 | Per-layer enable |
| lyr_pipe | input | 4 | Per-layer pipe select |
| lyr_prio | input | 8 | Per-layer 2-bit priority, layer i at [2i+1:2i] |
| lyr_org_x | input | 48 | Per-layer signed X origin, layer i at [12i+11:12i] |
| lyr_org_y | input | 48 | Per-layer signed Y origin |
| lyr_width | input | 48 | Per-layer width in pixels |
| lyr_height | input | 48 | Per-layer height in pixels |
| lyr_galpha | input | 32 | Per-layer global alpha, layer i at [8i+7:8i] |
| lyr_galpha_en | input | 4 | Per-layer global-alpha enable |
| lyr_argb | input | 128 | Per-layer ARGB pixel, layer i at [32i+31:32i] |
| bg_rgb | input | 24 | Background colour |
| out_rgb | output | 24 | Composed RGB pixel |

## Verification
Two functions collide at one pixel: the priority-0 defect substituting the background into pipe 0, and pipe 1 blending over that substituted value. The bench provokes this by giving the lowest pipe-0 layer a partial alpha, through the global alpha and separately through the per-pixel alpha. It places the pixel both where pipe 1 is empty and where an opaque or half-transparent pipe-1 layer overlaps. Each output is judged against a reference computed from the R6 and R7 formulas with the background standing in for P0.

// File: rtl/compositor_pkg.sv
package compositor_pkg;

    typedef struct packed {
        logic [23:0] p0_rgb;
        logic [23:0] p1_rgb;
        logic [7:0]  p1_alpha;
    } stage1_t;

    // Rounded division by 255 of a value up to 17 bits.
    function automatic logic [7:0] div255_round(input logic [16:0] v);
        logic [16:0] t;
        t = (v + 17'd127) / 17'd255;
        return t[7:0];
    endfunction

endpackage

// File: rtl/layer_cover.sv
module layer_cover #(
    parameter int CW = 12
) (
    input  logic [CW-1:0] pix_x,
    input  logic [CW-1:0] pix_y,
    input  logic [CW-1:0] org_x,
    input  logic [CW-1:0] org_y,
    input  logic [CW-1:0] width,
    input  logic [CW-1:0] height,
    input  logic [31:0]   argb,
    input  logic [7:0]    galpha,
    input  logic          galpha_en,
    output logic          hit,
    output logic [7:0]    eff_alpha
);
    import compositor_pkg::*;

    localparam int EW = CW + 2;

    logic signed [EW-1:0] px, py, lx, ly, rx, ry;
    logic [15:0] prod;

    assign px = $signed({2'b00, pix_x});
    assign py = $signed({2'b00, pix_y});
    assign lx = $signed({{2{org_x[CW-1]}}, org_x});
    assign ly = $signed({{2{org_y[CW-1]}}, org_y});
    assign rx = lx + $signed({2'b00, width});
    assign ry = ly + $signed({2'b00, height});

    assign hit = (px >= lx) && (px < rx) && (py >= ly) && (py < ry);

    always_comb begin
        prod = argb[31:24] * galpha;
        eff_alpha = galpha_en ? div255_round({1'b0, prod}) : argb[31:24];
    end

endmodule

// File: rtl/pipe_select.sv
module pipe_select #(
    parameter int NL  = 4,
    parameter int PW  = 2,
    parameter int IW  = 2,
    parameter bit SEL = 1'b0
) (
    input  logic [NL-1:0]    cand,
    input  logic [NL-1:0]    pipe,
    input  logic [NL*PW-1:0] prio,
    output logic             found,
    output logic [IW-1:0]    idx,
    output logic [PW-1:0]    win_prio
);
    always_comb begin
        found    = 1'b0;
        idx      = '0;
        win_prio = '0;
        for (int i = 0; i < NL; i++) begin
            if (cand[i] && (pipe[i] == SEL)) begin
                if (!found || (prio[i*PW +: PW] > win_prio)) begin
                    found    = 1'b1;
                    idx      = IW'(i);
                    win_prio = prio[i*PW +: PW];
                end
            end
        end
    end

endmodule

// File: rtl/pipe_blend.sv
module pipe_blend (
    input  logic [23:0] p0_rgb,
    input  logic [23:0] p1_rgb,
    input  logic [7:0]  alpha,
    output logic [23:0] rgb
);
    import compositor_pkg::*;

    logic [7:0] inv;
    assign inv = 8'd255 - alpha;

    for (genvar c = 0; c < 3; c++) begin : g_chan
        logic [15:0] t1, t0;
        logic [16:0] sum;
        always_comb begin
            t1  = alpha * p1_rgb[c*8 +: 8];
            t0  = inv * p0_rgb[c*8 +: 8];
            sum = {1'b0, t1} + {1'b0, t0};
            rgb[c*8 +: 8] = div255_round(sum);
        end
    end

endmodule

// File: rtl/layer_compositor.sv
module layer_compositor #(
    parameter int NL = 4,
    parameter int CW = 12,
    parameter int PW = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CW-1:0]    pix_x,
    input  logic [CW-1:0]    pix_y,
    input  logic [NL-1:0]    lyr_enable,
    input  logic [NL-1:0]    lyr_pipe,
    input  logic [NL*PW-1:0] lyr_prio,
    input  logic [NL*CW-1:0] lyr_org_x,
    input  logic [NL*CW-1:0] lyr_org_y,
    input  logic [NL*CW-1:0] lyr_width,
    input  logic [NL*CW-1:0] lyr_height,
    input  logic [NL*8-1:0]  lyr_galpha,
    input  logic [NL-1:0]    lyr_galpha_en,
    input  logic [NL*32-1:0] lyr_argb,
    input  logic [23:0]      bg_rgb,
    output logic [23:0]      out_rgb
);
    import compositor_pkg::*;

    localparam int IW = (NL > 1) ? $clog2(NL) : 1;

    logic [NL-1:0] hit;
    logic [7:0]    eff_a [NL];

    for (genvar i = 0; i < NL; i++) begin : g_layer
        layer_cover #(.CW(CW)) i_cover (
            .pix_x     (pix_x),
            .pix_y     (pix_y),
            .org_x     (lyr_org_x[i*CW +: CW]),
            .org_y     (lyr_org_y[i*CW +: CW]),
            .width     (lyr_width[i*CW +: CW]),
            .height    (lyr_height[i*CW +: CW]),
            .argb      (lyr_argb[i*32 +: 32]),
            .galpha    (lyr_galpha[i*8 +: 8]),
            .galpha_en (lyr_galpha_en[i]),
            .hit       (hit[i]),
            .eff_alpha (eff_a[i])
        );
    end

    logic [NL-1:0] cand;
    assign cand = hit & lyr_enable;

    logic          p0_found, p1_found;
    logic [IW-1:0] p0_idx, p1_idx;
    logic [PW-1:0] p0_prio, p1_prio;

    pipe_select #(.NL(NL), .PW(PW), .IW(IW), .SEL(1'b0)) i_sel0 (
        .cand (cand), .pipe (lyr_pipe), .prio (lyr_prio),
        .found (p0_found), .idx (p0_idx), .win_prio (p0_prio)
    );

    pipe_select #(.NL(NL), .PW(PW), .IW(IW), .SEL(1'b1)) i_sel1 (
        .cand (cand), .pipe (lyr_pipe), .prio (lyr_prio),
        .found (p1_found), .idx (p1_idx), .win_prio (p1_prio)
    );

    logic [7:0]  p0_alpha;
    logic [31:0] p0_argb, p1_argb;

    assign p0_alpha = eff_a[p0_idx];
    assign p0_argb  = lyr_argb[p0_idx*32 +: 32];
    assign p1_argb  = lyr_argb[p1_idx*32 +: 32];

    stage1_t     s1_d, s1_q;
    logic [23:0] out_d, out_q;
    logic [23:0] blend_rgb;

    pipe_blend i_blend (
        .p0_rgb (s1_q.p0_rgb),
        .p1_rgb (s1_q.p1_rgb),
        .alpha  (s1_q.p1_alpha),
        .rgb    (blend_rgb)
    );

    always_comb begin
        s1_d = '0;
        if (!p0_found) begin
            s1_d.p0_rgb = bg_rgb;
        end else if ((p0_prio == '0) && (p0_alpha != 8'hFF)) begin
            s1_d.p0_rgb = bg_rgb;
        end else begin
            s1_d.p0_rgb = p0_argb[23:0];
        end
        if (p1_found) begin
            s1_d.p1_rgb   = p1_argb[23:0];
            s1_d.p1_alpha = eff_a[p1_idx];
        end
        out_d = blend_rgb;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q  <= '0;
            out_q <= '0;
        end else begin
            s1_q  <= s1_d;
            out_q <= out_d;
        end
    end

    assign out_rgb = out_q;

endmodule

// File: rtl/compositor_chk.sv
module compositor_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        p0_found,
    input logic [1:0]  p0_prio,
    input logic [7:0]  p0_alpha,
    input logic        p1_found,
    input logic [23:0] p0_rgb_q,
    input logic [23:0] p1_rgb_q,
    input logic [7:0]  p1_alpha_q,
    input logic [23:0] bg_rgb,
    input logic [23:0] out_rgb
);
    // R7
    p1_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !p1_found |=> (p1_alpha_q == 8'd0));

    // R7
    opaque_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (p1_alpha_q == 8'hFF) |=> (out_rgb == $past(p1_rgb_q)));

    // R7
    clear_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (p1_alpha_q == 8'd0) |=> (out_rgb == $past(p0_rgb_q)));

    // R8
    lowest_defect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (p0_found && (p0_prio == 2'd0) && (p0_alpha != 8'hFF)) |=> (p0_rgb_q == $past(bg_rgb)));

    // R5
    p0_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !p0_found |=> (p0_rgb_q == $past(bg_rgb)));

endmodule

bind layer_compositor compositor_chk i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .p0_found   (p0_found),
    .p0_prio    (p0_prio),
    .p0_alpha   (p0_alpha),
    .p1_found   (p1_found),
    .p0_rgb_q   (s1_q.p0_rgb),
    .p1_rgb_q   (s1_q.p1_rgb),
    .p1_alpha_q (s1_q.p1_alpha),
    .bg_rgb     (bg_rgb),
    .out_rgb    (out_rgb)
);

// File: tb/test_layer_compositor.sv
module test_layer_compositor;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic [11:0] px, py;
    logic [11:0] ox [4], oy [4], wd [4], ht [4];
    logic [1:0]  pr [4];
    logic [7:0]  ga [4];
    logic [31:0] col [4];
    logic [3:0]  en, pipe, gen;
    logic [23:0] bg;
    logic [23:0] out_rgb;

    logic [7:0]   prio_f;
    logic [47:0]  ox_f, oy_f, wd_f, ht_f;
    logic [31:0]  ga_f;
    logic [127:0] col_f;

    always_comb begin
        for (int i = 0; i < 4; i++) begin
            prio_f[i*2 +: 2]   = pr[i];
            ox_f[i*12 +: 12]   = ox[i];
            oy_f[i*12 +: 12]   = oy[i];
            wd_f[i*12 +: 12]   = wd[i];
            ht_f[i*12 +: 12]   = ht[i];
            ga_f[i*8 +: 8]     = ga[i];
            col_f[i*32 +: 32]  = col[i];
        end
    end

    layer_compositor i_layer_compositor (
        .clk (clk), .rst_n (rst_n), .pix_x (px), .pix_y (py),
        .lyr_enable (en), .lyr_pipe (pipe), .lyr_prio (prio_f),
        .lyr_org_x (ox_f), .lyr_org_y (oy_f), .lyr_width (wd_f), .lyr_height (ht_f),
        .lyr_galpha (ga_f), .lyr_galpha_en (gen), .lyr_argb (col_f),
        .bg_rgb (bg), .out_rgb (out_rgb)
    );

    int checks = 0;
    int errors = 0;

    function automatic logic [7:0] rdiv(input int v);
        return 8'((v + 127) / 255);
    endfunction

    function automatic logic [7:0] mix(input int a, input int c1, input int c0);
        return rdiv(a * c1 + (255 - a) * c0);
    endfunction

    task automatic check(input string req, input logic [23:0] exp);
        checks++;
        if (out_rgb !== exp) begin
            errors++;
            $display("FAIL %s: out_rgb=%h expected=%h", req, out_rgb, exp);
        end
    endtask

    task automatic cfg_base();
        en = 4'b1111; pipe = 4'b1100; gen = 4'b0000; bg = 24'h404040;
        ox[0] = 12'd0;  oy[0] = 12'd0; wd[0] = 12'd16; ht[0] = 12'd16; pr[0] = 2'd0;
        col[0] = 32'hFF100000; ga[0] = 8'hFF;
        ox[1] = 12'd4;  oy[1] = 12'd4; wd[1] = 12'd4;  ht[1] = 12'd4;  pr[1] = 2'd2;
        col[1] = 32'hFF002000; ga[1] = 8'hFF;
        ox[2] = 12'd8;  oy[2] = 12'd0; wd[2] = 12'd8;  ht[2] = 12'd8;  pr[2] = 2'd1;
        col[2] = 32'hFF000030; ga[2] = 8'hFF;
        ox[3] = 12'hFFE; oy[3] = 12'hFFE; wd[3] = 12'd4; ht[3] = 12'd4; pr[3] = 2'd3;
        col[3] = 32'h00FFFFFF; ga[3] = 8'hFF;
    endtask

    // Drive at a falling edge, let two rising edges pass, sample at the next falling edge.
    task automatic run_pixel(input logic [11:0] x, input logic [11:0] y);
        @(negedge clk);
        px = x; py = y;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
    endtask

    // {x, y, expected rgb} under the base configuration
    localparam logic [47:0] VEC [10] = '{
        {12'd1,  12'd1,  24'h100000},
        {12'd5,  12'd5,  24'h002000},
        {12'd9,  12'd2,  24'h000030},
        {12'd20, 12'd20, 24'h404040},
        {12'd10, 12'd10, 24'h100000},
        {12'd3,  12'd3,  24'h100000},
        {12'd4,  12'd4,  24'h002000},
        {12'd8,  12'd7,  24'h000030},
        {12'd15, 12'd15, 24'h100000},
        {12'd16, 12'd0,  24'h404040}
    };

    initial begin
        #(20 * 100000);
        errors++;
        checks++;
        $display("FAIL watchdog: run did not finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        cfg_base();
        px = 12'd20; py = 12'd20;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 reset black", 24'h000000);
        rst_n = 1'b1;

        // R2 R4 R9: coverage edges and in-pipe priority, opaque layers
        for (int i = 0; i < 10; i++) begin
            run_pixel(VEC[i][47:36], VEC[i][35:24]);
            check("R2 R4 R9 vector", VEC[i][23:0]);
        end

        // R1: two-edge latency
        run_pixel(12'd20, 12'd20);
        @(negedge clk);
        px = 12'd5; py = 12'd5;
        @(posedge clk);
        @(negedge clk);
        check("R1 old value after one edge", 24'h404040);
        @(posedge clk);
        @(negedge clk);
        check("R1 new value after two edges", 24'h002000);

        // R3: disabled layer ignored
        cfg_base(); en[1] = 1'b0;
        run_pixel(12'd5, 12'd5);
        check("R3 disabled layer", 24'h100000);

        // R4: tie on priority goes to lower index
        cfg_base(); pr[1] = 2'd0;
        run_pixel(12'd5, 12'd5);
        check("R4 tie lower index", 24'h100000);

        // R4: priority in pipe 1
        cfg_base(); ox[3] = 12'd8; oy[3] = 12'd0; col[3] = 32'hFF000077;
        run_pixel(12'd9, 12'd2);
        check("R4 pipe1 priority", 24'h000077);

        // R7: per-pixel half alpha in pipe 1
        cfg_base(); col[2] = 32'h80FF0000;
        run_pixel(12'd9, 12'd2);
        check("R7 half blend", {mix(128, 255, 16), 8'h00, 8'h00});

        // R6: global alpha scales effective alpha
        cfg_base(); col[2] = 32'hFFFF0000; gen[2] = 1'b1; ga[2] = 8'h40;
        run_pixel(12'd9, 12'd2);
        check("R6 global alpha", {mix(int'(rdiv(255 * 64)), 255, 16), 8'h00, 8'h00});

        // R6: global alpha value ignored when its enable is clear
        gen[2] = 1'b0;
        run_pixel(12'd9, 12'd2);
        check("R6 global alpha disabled", 24'hFF0000);

        // R8: lowest layer with global alpha below opaque shows background
        cfg_base(); gen[0] = 1'b1; ga[0] = 8'hFE;
        run_pixel(12'd10, 12'd10);
        check("R8 defect global alpha", 24'h404040);

        // R8 with R7: defect and half-transparent pipe-1 blend in one pixel
        col[2] = 32'h80FF0000;
        run_pixel(12'd9, 12'd2);
        check("R8 R7 defect under blend", {mix(128, 255, 64), mix(128, 0, 64), mix(128, 0, 64)});

        // R8: per-pixel alpha below opaque
        cfg_base(); col[0] = 32'h7F100000;
        run_pixel(12'd10, 12'd10);
        check("R8 defect pixel alpha", 24'h404040);

        // R5: alpha of a non-zero-priority pipe-0 winner is not applied
        pr[0] = 2'd1;
        run_pixel(12'd10, 12'd10);
        check("R5 pipe0 alpha unused", 24'h100000);

        // R2: negative origin
        cfg_base(); col[3] = 32'hFF000077;
        run_pixel(12'd1, 12'd1);
        check("R2 negative origin inside", 24'h000077);
        run_pixel(12'd2, 12'd1);
        check("R2 negative origin outside", 24'h100000);

        // R9: moving a translucent layer to pipe 0 drops its blending
        cfg_base(); col[2] = 32'h80FF0000; pipe[2] = 1'b0;
        run_pixel(12'd9, 12'd2);
        check("R9 layer moved to pipe0", 24'hFF0000);

        // R5: background follows bg_rgb where nothing covers
        cfg_base(); bg = 24'h123456;
        run_pixel(12'd20, 12'd20);
        check("R5 background colour", 24'h123456);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule